// File: doc/BRIEF.md
# Flash Protected Range Checker

This block sits in front of a serial flash engine and decides, before any cycle starts, whether an access may proceed. Each request carries a byte start address, a byte count, and a kind bit that separates reads from writes and erases. The block tests every byte of the request against a bank of programmable protected ranges. It answers with exactly one of two outcomes, a grant or an access error. The flash engine starts a cycle only on a grant. A denied access never reaches the flash and never completes as a normal success.

The range bank holds a parameterised number of 32-bit range words. Each word gives a 4 KB-granular start page, an inclusive end page, and separate enables that protect the range against reads and against writes. Configuration logic fills the bank through a simple write port. A lockdown input freezes the whole bank until the next reset.

The decision is pipelined through two registers. A response appears a fixed two clocks after its request, and a new request can be accepted on every clock.

Top module: `flash_prot_checker`

## Requirements
- R1: A range word uses these bit positions: start page in bits 13:0, end page in bits 29:16, read-protect enable in bit 15, write-protect enable in bit 31. Writing `cfg_wdata` with `cfg_we` high loads the word into the range selected by `cfg_idx`.
- R2: A range covers the byte addresses from start×4096 up to end×4096+0xFFF, both ends included.
- R3: A request with `req_write`=1 (write or erase) is denied if any of its bytes lies in a range whose write-protect enable is set.
- R4: A request with `req_write`=0 (read) is denied if any of its bytes lies in a range whose read-protect enable is set. A range with only the write enable set does not block reads, and a range with only the read enable set does not block writes.
- R5: A range with both enables clear blocks nothing.
- R6: A range whose start page is greater than its end page blocks nothing.
- R7: `req_len_m1` holds the byte count minus one, so counts run from 1 to 2^LEN_W. The request spans `req_addr` to `req_addr+req_len_m1`. An overlap of only its first byte or only its last byte is enough to deny it.
- R8: `rsp_valid` is high in exactly the cycle two clocks after a cycle with `req_valid` high. Back-to-back requests give back-to-back responses. With `rsp_valid` low, `rsp_grant` and `rsp_err` are low.
- R9: With `rsp_valid` high, exactly one of `rsp_grant` and `rsp_err` is high. `rsp_err` is the access-error flag of a denied request.
- R10: A range write is ignored if `lock_in` is high in the same cycle or was high in any cycle since reset. The lock stays set after `lock_in` falls, and lockdown keeps the stored ranges unchanged.
- R11: Reset clears every range word and the lock, and holds all three response outputs low.
- R12: A write to an index at or above NUM_RANGES has no effect on any access decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_in | input | 1 | Lockdown request; freezes the range bank until reset |
| cfg_we | input | 1 | Range word write strobe |
| cfg_idx | input | IDX_W | Range index to write |
| cfg_wdata | input | 32 | Range word |
| req_valid | input | 1 | Access check request |
| req_addr | input | 26 | Byte start address of the access |
| req_len_m1 | input | LEN_W | Byte count minus one |
| req_write | input | 1 | 1 for write or erase, 0 for read |
| rsp_valid | output | 1 | Decision valid, two clocks after the request |
| rsp_grant | output | 1 | Access may start on the flash |
| rsp_err | output | 1 | Access denied; access-error flag |

## Verification
On every cycle, the assertions check the two-clock request-to-response spacing, that each response carries exactly one outcome, that no outcome appears without a response, and that the lock takes hold, stays set, and keeps the range bank unchanged. The bench's scenarios are the only way to show that the overlap arithmetic is right. They cover page-edge bytes on both sides of a range, 64-byte requests that touch a range with their last byte only, the separation between read and write protection, inverted and disabled ranges, out-of-range indices, and writes that arrive together with or after lockdown.

// File: rtl/frc_pkg.sv
package frc_pkg;

    localparam int FIELD_W    = 14;
    localparam int PAGE_W     = 12;
    localparam int ADDR_W     = FIELD_W + PAGE_W;
    localparam int WORD_W     = 32;
    localparam int BASE_LSB   = 0;
    localparam int LIMIT_LSB  = 16;
    localparam int RD_EN_BIT  = 15;
    localparam int WR_EN_BIT  = 31;
    localparam int RANGE_BITS = 2 + 2 * FIELD_W;

    typedef struct packed {
        logic               wr_en;
        logic               rd_en;
        logic [FIELD_W-1:0] first_pg;
        logic [FIELD_W-1:0] last_pg;
    } range_t;

    typedef enum logic {
        ACC_READ  = 1'b0,
        ACC_WRITE = 1'b1
    } acc_kind_e;

    function automatic range_t decode_word(input logic [WORD_W-1:0] w);
        range_t r;
        r.wr_en    = w[WR_EN_BIT];
        r.rd_en    = w[RD_EN_BIT];
        r.first_pg = w[BASE_LSB +: FIELD_W];
        r.last_pg  = w[LIMIT_LSB +: FIELD_W];
        return r;
    endfunction

    function automatic logic [ADDR_W:0] page_lo(input logic [FIELD_W-1:0] pg);
        return {1'b0, pg, {PAGE_W{1'b0}}};
    endfunction

    function automatic logic [ADDR_W:0] page_hi(input logic [FIELD_W-1:0] pg);
        return {1'b0, pg, {PAGE_W{1'b1}}};
    endfunction

endpackage

// File: rtl/frc_range_bank.sv
module frc_range_bank
    import frc_pkg::*;
#(
    parameter int NUM_RANGES = 5,
    parameter int IDX_W      = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    lock_in,
    input  logic                    cfg_we,
    input  logic [IDX_W-1:0]        cfg_idx,
    input  logic [WORD_W-1:0]       cfg_wdata,
    output range_t [NUM_RANGES-1:0] ranges_o,
    output logic                    locked_o
);

    logic   lock_q;
    logic   write_ok;
    range_t new_range;
    logic   unused_rsvd;

    assign write_ok    = cfg_we && !lock_in && !lock_q;
    assign new_range   = decode_word(cfg_wdata);
    assign unused_rsvd = ^{cfg_wdata[30], cfg_wdata[14]};
    assign locked_o    = lock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b0;
        end else if (lock_in) begin
            lock_q <= 1'b1;
        end
    end

    for (genvar i = 0; i < NUM_RANGES; i++) begin : g_slot
        range_t slot_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q <= '0;
            end else if (write_ok && (cfg_idx == IDX_W'(i))) begin
                slot_q <= new_range;
            end
        end
        assign ranges_o[i] = slot_q;
    end

endmodule

// File: rtl/frc_range_cmp.sv
module frc_range_cmp
    import frc_pkg::*;
(
    input  range_t          rng,
    input  logic [ADDR_W:0] acc_lo,
    input  logic [ADDR_W:0] acc_hi,
    input  acc_kind_e       kind,
    output logic            hit
);

    logic            enabled;
    logic            span_ok;
    logic [ADDR_W:0] span_lo;
    logic [ADDR_W:0] span_hi;

    always_comb begin
        enabled = (kind == ACC_WRITE) ? rng.wr_en : rng.rd_en;
        span_ok = (rng.first_pg <= rng.last_pg);
        span_lo = page_lo(rng.first_pg);
        span_hi = page_hi(rng.last_pg);
        hit     = enabled && span_ok && (acc_lo <= span_hi) && (acc_hi >= span_lo);
    end

endmodule

// File: rtl/frc_decide.sv
module frc_decide #(
    parameter int NUM_RANGES = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  s1_valid,
    input  logic [NUM_RANGES-1:0] s1_hits,
    output logic                  rsp_valid,
    output logic                  rsp_grant,
    output logic                  rsp_err
);

    logic any_hit;

    assign any_hit = |s1_hits;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_grant <= 1'b0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= s1_valid;
            rsp_grant <= s1_valid && !any_hit;
            rsp_err   <= s1_valid && any_hit;
        end
    end

endmodule

// File: rtl/flash_prot_checker.sv
module flash_prot_checker
    import frc_pkg::*;
#(
    parameter int NUM_RANGES = 5,
    parameter int IDX_W      = 3,
    parameter int LEN_W      = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lock_in,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [31:0]       cfg_wdata,
    input  logic              req_valid,
    input  logic [25:0]       req_addr,
    input  logic [LEN_W-1:0]  req_len_m1,
    input  logic              req_write,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic              rsp_err
);

    localparam int PAD_W = ADDR_W + 1 - LEN_W;

    range_t [NUM_RANGES-1:0] ranges;
    logic                    bank_locked;
    logic [ADDR_W:0]         acc_lo;
    logic [ADDR_W:0]         acc_hi;
    acc_kind_e               kind;
    logic [NUM_RANGES-1:0]   hit_vec;
    logic                    s1_valid;
    logic [NUM_RANGES-1:0]   s1_hits;

    frc_range_bank #(
        .NUM_RANGES (NUM_RANGES),
        .IDX_W      (IDX_W)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .lock_in   (lock_in),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .ranges_o  (ranges),
        .locked_o  (bank_locked)
    );

    assign acc_lo = {1'b0, req_addr};
    assign acc_hi = {1'b0, req_addr} + {{PAD_W{1'b0}}, req_len_m1};
    assign kind   = acc_kind_e'(req_write);

    for (genvar i = 0; i < NUM_RANGES; i++) begin : g_cmp
        frc_range_cmp u_cmp (
            .rng    (ranges[i]),
            .acc_lo (acc_lo),
            .acc_hi (acc_hi),
            .kind   (kind),
            .hit    (hit_vec[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_hits  <= '0;
        end else begin
            s1_valid <= req_valid;
            s1_hits  <= req_valid ? hit_vec : '0;
        end
    end

    frc_decide #(
        .NUM_RANGES (NUM_RANGES)
    ) u_decide (
        .clk       (clk),
        .rst       (rst),
        .s1_valid  (s1_valid),
        .s1_hits   (s1_hits),
        .rsp_valid (rsp_valid),
        .rsp_grant (rsp_grant),
        .rsp_err   (rsp_err)
    );

endmodule

// File: rtl/flash_prot_checker_sva.sv
module flash_prot_checker_sva
    import frc_pkg::*;
#(
    parameter int NUM_RANGES = 5
) (
    input logic                             clk,
    input logic                             rst,
    input logic                             req_valid,
    input logic                             lock_in,
    input logic                             locked,
    input logic [NUM_RANGES*RANGE_BITS-1:0] ranges_flat,
    input logic                             rsp_valid,
    input logic                             rsp_grant,
    input logic                             rsp_err
);

    logic req_d1;
    logic req_d2;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_d1 <= 1'b0;
            req_d2 <= 1'b0;
        end else begin
            req_d1 <= req_valid;
            req_d2 <= req_d1;
        end
    end

    a_r8_two_clock_latency: assert property (@(posedge clk) disable iff (rst)
        rsp_valid == req_d2);

    a_r8_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!rsp_grant && !rsp_err));

    a_r9_single_outcome: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_grant != rsp_err));

    a_r10_lock_takes_hold: assert property (@(posedge clk) disable iff (rst)
        lock_in |=> locked);

    a_r10_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked);

    a_r10_bank_frozen: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(ranges_flat));

endmodule

bind flash_prot_checker flash_prot_checker_sva #(
    .NUM_RANGES (NUM_RANGES)
) u_sva (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .lock_in     (lock_in),
    .locked      (bank_locked),
    .ranges_flat (ranges),
    .rsp_valid   (rsp_valid),
    .rsp_grant   (rsp_grant),
    .rsp_err     (rsp_err)
);

// File: tb/flash_prot_checker_tb_top.sv
module flash_prot_checker_tb_top;

    localparam int NR    = 5;
    localparam int IDX_W = 3;
    localparam int LEN_W = 6;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             lock_in = 1'b0;
    logic             cfg_we = 1'b0;
    logic [IDX_W-1:0] cfg_idx = '0;
    logic [31:0]      cfg_wdata = '0;
    logic             req_valid = 1'b0;
    logic [25:0]      req_addr = '0;
    logic [LEN_W-1:0] req_len_m1 = '0;
    logic             req_write = 1'b0;
    logic             rsp_valid;
    logic             rsp_grant;
    logic             rsp_err;

    string cur_tag = "R11";

    int n_cmp = 0;
    int n_bad = 0;
    bit started = 1'b0;
    bit done = 1'b0;

    // reference model state
    logic [31:0] m_rng [NR];
    bit          m_lock;
    bit          e1_v, e1_g, e1_e, e2_v, e2_g, e2_e;
    string       e1_tag = "R11";
    string       e2_tag = "R11";

    always #4ns clk = ~clk;

    flash_prot_checker #(
        .NUM_RANGES (NR),
        .IDX_W      (IDX_W),
        .LEN_W      (LEN_W)
    ) dut_i (
        .clk        (clk),
        .rst        (rst),
        .lock_in    (lock_in),
        .cfg_we     (cfg_we),
        .cfg_idx    (cfg_idx),
        .cfg_wdata  (cfg_wdata),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_len_m1 (req_len_m1),
        .req_write  (req_write),
        .rsp_valid  (rsp_valid),
        .rsp_grant  (rsp_grant),
        .rsp_err    (rsp_err)
    );

    // behavioural decision: any byte of the access inside an enabled, non-inverted range
    function automatic bit model_deny(longint addr, longint len_m1, bit wr);
        longint lo = addr;
        longint hi = addr + len_m1;
        for (int i = 0; i < NR; i++) begin
            longint b  = longint'(m_rng[i][13:0]);
            longint l  = longint'(m_rng[i][29:16]);
            bit     en = wr ? m_rng[i][31] : m_rng[i][15];
            if (en && (b <= l) && (lo <= l * 4096 + 4095) && (hi >= b * 4096))
                return 1'b1;
        end
        return 1'b0;
    endfunction

    always @(posedge clk) begin
        bit d;
        started = 1'b1;
        if (rst) begin
            e1_v = 0; e1_g = 0; e1_e = 0; e1_tag = "R11";
            e2_v = 0; e2_g = 0; e2_e = 0; e2_tag = "R11";
            m_lock = 0;
            for (int i = 0; i < NR; i++) m_rng[i] = '0;
        end else begin
            e2_v = e1_v; e2_g = e1_g; e2_e = e1_e; e2_tag = e1_tag;
            if (req_valid) begin
                d = model_deny(longint'(req_addr), longint'(req_len_m1), req_write);
                e1_v = 1; e1_g = !d; e1_e = d; e1_tag = cur_tag;
            end else begin
                e1_v = 0; e1_g = 0; e1_e = 0; e1_tag = "R8";
            end
            if (cfg_we && !lock_in && !m_lock && (int'(cfg_idx) < NR))
                m_rng[cfg_idx] = cfg_wdata;
            if (lock_in) m_lock = 1;
        end
    end

    always @(negedge clk) begin
        if (started) begin
            n_cmp++;
            if (rsp_valid !== e2_v || rsp_grant !== e2_g || rsp_err !== e2_e) begin
                n_bad++;
                $display("FAIL %s: got valid=%b grant=%b err=%b, expected valid=%b grant=%b err=%b",
                         e2_tag, rsp_valid, rsp_grant, rsp_err, e2_v, e2_g, e2_e);
            end
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cfg_we = 0; req_valid = 0; lock_in = 0;
        end
    endtask

    task automatic cfg(int idx, logic [31:0] w, bit lk);
        @(negedge clk);
        req_valid = 0; cfg_we = 1; cfg_idx = IDX_W'(idx); cfg_wdata = w; lock_in = lk;
    endtask

    task automatic acc(logic [25:0] a, int lm1, bit wr, string tag);
        @(negedge clk);
        cfg_we = 0; lock_in = 0;
        req_valid = 1; req_addr = a; req_len_m1 = LEN_W'(lm1); req_write = wr; cur_tag = tag;
    endtask

    initial begin
        // R11: reset state observed for several cycles
        cur_tag = "R11";
        repeat (3) @(negedge clk);
        rst = 0;
        acc(26'h0002000, 0, 1, "R11");
        acc(26'h0000000, 63, 0, "R11");
        idle(3);

        // R1, R2, R3: write-protected pages 2..3 in slot 0
        cfg(0, 32'h8003_0002, 0);
        acc(26'h0002000, 0, 1, "R3");
        acc(26'h0001FFF, 0, 1, "R2");
        acc(26'h0003FFF, 0, 1, "R2");
        acc(26'h0004000, 0, 1, "R2");
        acc(26'h0003000, 15, 1, "R1");
        // R7: first or last byte overlap
        acc(26'h0001FFF, 1, 1, "R7");
        acc(26'h0001FC0, 63, 1, "R7");
        acc(26'h0001FC1, 63, 1, "R7");
        acc(26'h0003FFF, 63, 1, "R7");
        // R4: write-only range does not block reads
        acc(26'h0002000, 63, 0, "R4");
        idle(2);

        // R4: read-protected page 10 in slot 1
        cfg(1, 32'h000A_800A, 0);
        acc(26'h000A800, 3, 0, "R4");
        acc(26'h000A800, 3, 1, "R4");
        acc(26'h0009FFF, 0, 0, "R4");
        acc(26'h000B000, 0, 0, "R4");
        // R5: no enables over whole space
        cfg(2, 32'h3FFF_0000, 0);
        acc(26'h0100000, 7, 1, "R5");
        acc(26'h0100000, 7, 0, "R5");
        // R6: inverted range 20..19
        cfg(3, 32'h8013_0014, 0);
        acc(26'h0014000, 0, 1, "R6");
        acc(26'h0013000, 0, 1, "R6");
        // R12: index beyond bank
        cfg(7, 32'hBFFF_8000, 0);
        cfg(5, 32'hBFFF_8000, 0);
        acc(26'h0200000, 0, 1, "R12");
        acc(26'h0200000, 0, 0, "R12");
        idle(2);

        // R8, R9: back-to-back mixed requests
        for (int k = 0; k < 16; k++) begin
            acc(26'h0001FF0 + 26'(k * 700), k % 8 * 8, k % 2, "R8");
        end
        idle(3);

        // R10: write in the lock cycle and after are ignored
        cfg(4, 32'hBFFF_8000, 1);
        cfg(0, 32'h0000_0000, 0);
        cfg(4, 32'hBFFF_8000, 0);
        acc(26'h0002000, 0, 1, "R10");
        acc(26'h0800000, 0, 1, "R10");
        acc(26'h0800000, 0, 0, "R10");
        idle(3);

        // R11: reset clears bank and lock
        @(negedge clk); rst = 1;
        idle(2);
        @(negedge clk); rst = 0;
        acc(26'h0002000, 0, 1, "R11");
        acc(26'h000A800, 0, 0, "R11");
        cfg(4, 32'hBFFF_8000, 0);
        acc(26'h0800000, 0, 1, "R1");
        acc(26'h3FFFFFF, 0, 0, "R1");
        acc(26'h3FFFFC0, 63, 1, "R2");
        idle(4);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #200us;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got no completion, expected end of scenario list");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule